// File: doc/BRIEF.md
# Two-Phase Character Cell Video Fetcher

This block turns a character-cell screen into a monochrome serial pixel stream while using only one single-ported 8K video RAM. Every character period, which is eight dot clocks long, is split in half. In the first half, the RAM address is the screen address taken from an external CRT-controller-style counter, and the character code that the RAM returns is captured at the midpoint. In the second half, that captured code and the current character row together address a glyph region of the same RAM. The glyph byte returned in the last dot of the period is loaded into a shift register, and the shift register sends it out one pixel per dot during the next period.

The block also derives the CPU clock (dot/4) and the character clock (dot/8) from the dot clock. It delays display enable and cursor by one character period so that they line up with the pixel stream. It blanks the output while display enable is off, and it inverts pixels while cursor is on. The RAM is external and has an asynchronous read port: the block drives `ram_addr` and reads `ram_rdata` back in the same dot.

The 8K RAM holds four 2K regions, selected by address bits 12:11: 0 is the screen, 1 is the standard glyphs, 2 is the programmable glyphs and 3 is the small font.

Top module: `cellvid_fetch`

## Requirements
- R1: While `rst_n` is low, `clk_cpu` and `clk_char` are both 0. After reset is released, a dot counter `k` runs 0..7 and starts at 0 in the first dot. `clk_char` is 0 for `k` = 0..3 and 1 for `k` = 4..7. `clk_cpu` equals bit 1 of `k`.
- R2: While `clk_char` is 0, `ram_addr` equals `{2'b00, scr_addr[10:0]}`. `scr_addr` bits 12:11 have no effect.
- R3: While `clk_char` is 1, `ram_addr[3:0]` equals `row_addr` and `ram_addr[10:4]` equals bits 6:0 of the code. The code is the value of `ram_rdata` in the last dot of the low phase (`k` = 3).
- R4: In the high phase, `ram_addr[12:11]` is 2 when code bit 7 is set. Otherwise it is 3 when `scr_addr[13]` was 1 in dot `k` = 3, and 1 when it was 0. Code bit 7 takes priority over `scr_addr[13]`.
- R5: The `ram_rdata` value in dot `k` = 7 is the glyph byte. It appears on `pixel_out` during dots `k` = 0..7 of the next period, MSB first, one bit per dot.
- R6: `pixel_out` is 0 during any period whose preceding period had `disp_en` = 0 in its dot `k` = 7.
- R7: During a period whose preceding period had `disp_en` = 1 and `cursor` = 1 in its dot `k` = 7, each glyph bit is inverted on `pixel_out`.
- R8: While in reset, and throughout the first period after reset, `pixel_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scr_addr | input | 14 | Screen address; bits 10:0 index the screen, bit 13 selects the small font |
| row_addr | input | 4 | Character row (scan line within the cell) |
| disp_en | input | 1 | Display enable from the timing counter |
| cursor | input | 1 | Cursor flag from the timing counter |
| ram_rdata | input | 8 | Asynchronous read data from the video RAM |
| ram_addr | output | 13 | Video RAM address |
| clk_cpu | output | 1 | Dot clock divided by 4 |
| clk_char | output | 1 | Dot clock divided by 8 |
| pixel_out | output | 1 | Serial video after blanking and cursor inversion |

## Verification
A wrong dot-counter state shows at the ports at once: `clk_char` and `clk_cpu` stop matching the dot position, and the RAM address switches between screen and glyph form in the wrong dots. A wrongly captured code or font select shows in `ram_addr` during the first glyph dot of the same period. A bad glyph, shift order, or enable/cursor delay shows on `pixel_out` in the first dot of the following period. The bench therefore compares every port in every dot against a model driven only by the dot position and its own copy of the RAM contents.

// File: rtl/cellvid_pkg.sv
package cellvid_pkg;

   typedef enum logic [1:0] {
      RGN_SCREEN = 2'd0,
      RGN_STD    = 2'd1,
      RGN_USER   = 2'd2,
      RGN_SMALL  = 2'd3
   } region_e;

   // Glyph region: high code bit wins over the small-font select.
   function automatic logic [1:0] pick_region(input logic code_hi, input logic small_sel);
      logic [1:0] r;
      if (code_hi)        r = RGN_USER;
      else if (small_sel) r = RGN_SMALL;
      else                r = RGN_STD;
      return r;
   endfunction

endpackage

// File: rtl/cellvid_clkdiv.sv
module cellvid_clkdiv #(
   parameter int DIV_BITS = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic clk_cpu,
   output logic clk_char,
   output logic mid_stb,
   output logic load_stb
);
   localparam logic [DIV_BITS-1:0] MID_VAL = DIV_BITS'((1 << (DIV_BITS-1)) - 1);

   logic [DIV_BITS-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign clk_cpu  = cnt_q[1];
   assign clk_char = cnt_q[DIV_BITS-1];
   assign mid_stb  = (cnt_q == MID_VAL);
   // all taps high: last dot of the character period
   assign load_stb = &cnt_q;

endmodule

// File: rtl/cellvid_addr_mux.sv
module cellvid_addr_mux
   import cellvid_pkg::*;
#(
   parameter int CHAR_W    = 8,
   parameter int ROW_W     = 4,
   parameter int SCR_W     = 14,
   parameter int SCR_IDX_W = 11,
   parameter int ADDR_W    = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 glyph_phase,
   input  logic                 mid_stb,
   input  logic [SCR_W-1:0]     scr_addr,
   input  logic [ROW_W-1:0]     row_addr,
   input  logic [CHAR_W-1:0]    ram_rdata,
   output logic [ADDR_W-1:0]    ram_addr
);
   logic [CHAR_W-1:0] code_q;
   logic              small_q;
   logic [1:0]        rgn;
   logic [1:0]        scr_rgn;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= '0;
         small_q <= 1'b0;
      end else if (mid_stb) begin
         code_q  <= ram_rdata;
         small_q <= scr_addr[SCR_W-1];
      end
   end

   always_comb begin
      rgn     = pick_region(code_q[CHAR_W-1], small_q);
      scr_rgn = RGN_SCREEN;
      if (glyph_phase) ram_addr = {rgn, code_q[CHAR_W-2:0], row_addr};
      else             ram_addr = {scr_rgn, scr_addr[SCR_IDX_W-1:0]};
   end

endmodule

// File: rtl/cellvid_shifter.sv
module cellvid_shifter #(
   parameter int CHAR_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_stb,
   input  logic [CHAR_W-1:0] glyph,
   output logic              bit_out
);
   logic [CHAR_W-1:0] sh_q;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk) begin
            if (!rst_n)        sh_q <= '0;
            else if (load_stb) sh_q <= glyph;
            else               sh_q <= {sh_q[CHAR_W-2:0], 1'b0};
         end
         assign bit_out = sh_q[CHAR_W-1];
      end else begin : g_lsb
         always_ff @(posedge clk) begin
            if (!rst_n)        sh_q <= '0;
            else if (load_stb) sh_q <= glyph;
            else               sh_q <= {1'b0, sh_q[CHAR_W-1:1]};
         end
         assign bit_out = sh_q[0];
      end
   endgenerate

endmodule

// File: rtl/cellvid_gate.sv
module cellvid_gate #(
   parameter int CELL_DELAY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_stb,
   input  logic disp_en,
   input  logic cursor,
   input  logic pix_in,
   output logic pix_out
);
   logic de_c;
   logic cur_c;

   generate
      if (CELL_DELAY == 0) begin : g_direct
         assign de_c  = disp_en;
         assign cur_c = cursor;
      end else begin : g_pipe
         logic [CELL_DELAY-1:0] de_p;
         logic [CELL_DELAY-1:0] cur_p;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               de_p  <= '0;
               cur_p <= '0;
            end else if (load_stb) begin
               de_p[0]  <= disp_en;
               cur_p[0] <= cursor;
               for (int i = 1; i < CELL_DELAY; i++) begin
                  de_p[i]  <= de_p[i-1];
                  cur_p[i] <= cur_p[i-1];
               end
            end
         end
         assign de_c  = de_p[CELL_DELAY-1];
         assign cur_c = cur_p[CELL_DELAY-1];
      end
   endgenerate

   assign pix_out = de_c & (pix_in ^ cur_c);

endmodule

// File: rtl/cellvid_fetch.sv
module cellvid_fetch #(
   parameter int CHAR_W     = 8,
   parameter int ROW_W      = 4,
   parameter int SCR_W      = 14,
   parameter int CELL_DELAY = 1,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SCR_W-1:0]  scr_addr,
   input  logic [ROW_W-1:0]  row_addr,
   input  logic              disp_en,
   input  logic              cursor,
   input  logic [CHAR_W-1:0] ram_rdata,
   output logic [2+CHAR_W-1+ROW_W-1:0] ram_addr,
   output logic              clk_cpu,
   output logic              clk_char,
   output logic              pixel_out
);
   localparam int DIV_BITS  = $clog2(CHAR_W);
   localparam int ADDR_W    = 2 + (CHAR_W - 1) + ROW_W;
   localparam int SCR_IDX_W = ADDR_W - 2;

   generate
      if ((1 << DIV_BITS) != CHAR_W || DIV_BITS < 2) begin : g_bad_w
         $error("CHAR_W must be a power of two of at least 4");
      end
      if (SCR_W < SCR_IDX_W + 1) begin : g_bad_scr
         $error("SCR_W too narrow for screen index plus font select");
      end
      if (CELL_DELAY < 0) begin : g_bad_dly
         $error("CELL_DELAY must not be negative");
      end
   endgenerate

   logic mid_stb;
   logic load_stb;
   logic raw_pix;

   cellvid_clkdiv #(.DIV_BITS(DIV_BITS)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_cpu  (clk_cpu),
      .clk_char (clk_char),
      .mid_stb  (mid_stb),
      .load_stb (load_stb)
   );

   cellvid_addr_mux #(
      .CHAR_W    (CHAR_W),
      .ROW_W     (ROW_W),
      .SCR_W     (SCR_W),
      .SCR_IDX_W (SCR_IDX_W),
      .ADDR_W    (ADDR_W)
   ) u_mux (
      .clk         (clk),
      .rst_n       (rst_n),
      .glyph_phase (clk_char),
      .mid_stb     (mid_stb),
      .scr_addr    (scr_addr),
      .row_addr    (row_addr),
      .ram_rdata   (ram_rdata),
      .ram_addr    (ram_addr)
   );

   cellvid_shifter #(.CHAR_W(CHAR_W), .MSB_FIRST(MSB_FIRST)) u_sh (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_stb (load_stb),
      .glyph    (ram_rdata),
      .bit_out  (raw_pix)
   );

   cellvid_gate #(.CELL_DELAY(CELL_DELAY)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_stb (load_stb),
      .disp_en  (disp_en),
      .cursor   (cursor),
      .pix_in   (raw_pix),
      .pix_out  (pixel_out)
   );

endmodule

// File: rtl/cellvid_fetch_chk.sv
module cellvid_fetch_chk #(
   parameter int CHAR_W = 8,
   parameter int ROW_W  = 4,
   parameter int SCR_W  = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SCR_W-1:0]  scr_addr,
   input logic [ROW_W-1:0]  row_addr,
   input logic              disp_en,
   input logic [2+CHAR_W-1+ROW_W-1:0] ram_addr,
   input logic              clk_cpu,
   input logic              clk_char,
   input logic              pixel_out
);
   localparam int PB = $clog2(CHAR_W);
   localparam int AW = 2 + CHAR_W - 1 + ROW_W;
   localparam int IW = AW - 2;

   // Independent dot-position counter and one-period enable history
   logic [PB-1:0] ph_q;
   logic          de_cell_q;
   logic          first_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q      <= '0;
         de_cell_q <= 1'b0;
         first_q   <= 1'b1;
      end else begin
         ph_q <= ph_q + 1'b1;
         if (&ph_q) begin
            de_cell_q <= disp_en;
            first_q   <= 1'b0;
         end
      end
   end

   p_char_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clk_char == ph_q[PB-1]);

   p_cpu_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clk_cpu == ph_q[1]);

   p_screen_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_char |-> (ram_addr[AW-1:IW] == 2'b00 && ram_addr[IW-1:0] == scr_addr[IW-1:0]));

   p_glyph_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clk_char |-> ram_addr[ROW_W-1:0] == row_addr);

   p_glyph_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clk_char |-> ram_addr[AW-1:IW] != 2'b00);

   p_region_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_char && $past(clk_char)) |-> $stable(ram_addr[AW-1:IW]));

   p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !de_cell_q |-> !pixel_out);

   p_first_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      first_q |-> !pixel_out);

endmodule

bind cellvid_fetch cellvid_fetch_chk #(
   .CHAR_W (CHAR_W),
   .ROW_W  (ROW_W),
   .SCR_W  (SCR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scr_addr  (scr_addr),
   .row_addr  (row_addr),
   .disp_en   (disp_en),
   .ram_addr  (ram_addr),
   .clk_cpu   (clk_cpu),
   .clk_char  (clk_char),
   .pixel_out (pixel_out)
);

// File: tb/tb_cellvid_fetch.sv
module tb_cellvid_fetch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] scr_addr = '0;
   logic [3:0]  row_addr = '0;
   logic        disp_en = 1'b0;
   logic        cursor = 1'b0;
   logic [7:0]  ram_rdata;
   logic [12:0] ram_addr;
   logic        clk_cpu;
   logic        clk_char;
   logic        pixel_out;

   logic [7:0] mem [0:8191];

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // previous-period expectations
   logic [7:0] p_glyph = 8'h00;
   logic       p_de = 1'b0;
   logic       p_cur = 1'b0;

   always #5 clk = ~clk;

   assign ram_rdata = mem[ram_addr];

   cellvid_fetch dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scr_addr  (scr_addr),
      .row_addr  (row_addr),
      .disp_en   (disp_en),
      .cursor    (cursor),
      .ram_rdata (ram_rdata),
      .ram_addr  (ram_addr),
      .clk_cpu   (clk_cpu),
      .clk_char  (clk_char),
      .pixel_out (pixel_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [12:0] glyph_addr(input logic [13:0] s, input logic [7:0] code,
                                              input logic [3:0] row);
      logic [1:0] rg;
      rg = code[7] ? 2'd2 : (s[13] ? 2'd3 : 2'd1);
      return {rg, code[6:0], row};
   endfunction

   // One character period; called at a negedge with dot k = 0
   task automatic run_cell(input logic [13:0] s, input logic [3:0] row,
                           input logic de, input logic cur);
      logic [12:0] saddr;
      logic [12:0] gaddr;
      logic [7:0]  code;
      logic [7:0]  gl;
      logic        ep;
      scr_addr = s;
      row_addr = row;
      disp_en  = de;
      cursor   = cur;
      saddr = {2'b00, s[10:0]};
      code  = mem[saddr];
      gaddr = glyph_addr(s, code, row);
      gl    = mem[gaddr];
      for (int k = 0; k < 8; k++) begin
         #1;
         check(clk_char == (k >= 4), "R1 clk_char", clk_char, k >= 4);
         check(clk_cpu == k[1], "R1 clk_cpu", clk_cpu, k[1]);
         if (k < 4) check(ram_addr == saddr, "R2 screen addr", ram_addr, saddr);
         else if (k == 4) begin
            check(ram_addr[10:0] == gaddr[10:0], "R3 glyph code/row", ram_addr, gaddr);
            check(ram_addr[12:11] == gaddr[12:11], "R4 glyph region", ram_addr[12:11], gaddr[12:11]);
         end else check(ram_addr == gaddr, "R3 glyph addr hold", ram_addr, gaddr);
         ep = p_de ? (p_glyph[7-k] ^ p_cur) : 1'b0;
         if (!p_de)      check(pixel_out == ep, "R6 blank", pixel_out, ep);
         else if (p_cur) check(pixel_out == ep, "R7 cursor invert", pixel_out, ep);
         else            check(pixel_out == ep, "R5 pixel order", pixel_out, ep);
         @(negedge clk);
      end
      p_glyph = gl;
      p_de    = de;
      p_cur   = cur;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      for (int i = 0; i < 8192; i++) mem[i] = 8'($urandom);

      // R8: reset state
      repeat (3) @(negedge clk);
      #1;
      check(pixel_out == 1'b0, "R8 reset pixel", pixel_out, 0);
      check(clk_char == 1'b0 && clk_cpu == 1'b0, "R1 reset clocks", {clk_char, clk_cpu}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R8: first period after reset stays dark even with enable and cursor
      run_cell(14'h0123, 4'd2, 1'b1, 1'b1);

      // R4: code < 128 with small select clear -> standard region
      mem[13'h0010] = 8'h41;
      mem[{2'd1, 7'h41, 4'd0}] = 8'b1010_0011;
      run_cell(14'h0010, 4'd0, 1'b1, 1'b0);
      // R4: code < 128 with small select set -> small font region; R5 order shown
      mem[{2'd3, 7'h41, 4'd15}] = 8'b1000_0001;
      run_cell(14'h2010, 4'd15, 1'b1, 1'b0);
      // R4: code >= 128 wins over small select -> programmable region
      mem[13'h0020] = 8'hC1;
      mem[{2'd2, 7'h41, 4'd7}] = 8'hFF;
      run_cell(14'h2020, 4'd7, 1'b1, 1'b1);
      // R7: all-ones glyph under cursor goes dark; all-zero glyph goes bright
      mem[13'h0030] = 8'h00;
      mem[{2'd1, 7'h00, 4'd3}] = 8'h00;
      run_cell(14'h0030, 4'd3, 1'b1, 1'b1);
      // R2: bits 12:11 ignored in screen phase
      run_cell(14'h1830, 4'd3, 1'b0, 1'b0);
      // R6: disabled cell with cursor still blank
      run_cell(14'h0020, 4'd7, 1'b0, 1'b1);
      run_cell(14'h0010, 4'd0, 1'b1, 1'b0);

      for (int n = 0; n < 1500; n++) begin
         logic [13:0] s;
         s = 14'($urandom);
         run_cell(s, 4'($urandom), ($urandom % 4) != 0, ($urandom % 5) == 0);
      end

      // R1/R8: reset in mid-stream returns to dot 0 and a dark first period
      rst_n = 1'b0;
      p_de = 1'b0;
      @(negedge clk);
      #1;
      check(pixel_out == 1'b0, "R8 re-reset pixel", pixel_out, 0);
      @(negedge clk);
      rst_n = 1'b1;
      run_cell(14'h0010, 4'd0, 1'b1, 1'b0);
      run_cell(14'h0020, 4'd7, 1'b1, 1'b0);
      run_cell(14'h0030, 4'd1, 1'b1, 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule